// File: doc/BRIEF.md
# Multi-Level Radix Table Walker

This block turns a virtual address into a real address by following a radix tree of 64-bit entries held in memory. A request supplies the address, the byte address of the root table, the index width of the root table and the total number of translated address bits. At each level the walker takes an index from the address, reads one entry through a memory read port, and either goes down to the next table or stops at a leaf. Each directory entry sets the index width and base address of the next table, so the tree shape is chosen by the tables themselves.

Requests use a valid/ready handshake: a request is taken only while no walk is running, and a requester that sees `req_ready` low must keep its request unchanged. The read request channel also uses valid/ready. The memory may hold off `rd_ready` for any number of cycles, and the walker keeps its address stable until the read is accepted. Read data comes back on `rd_rsp_valid` with no back-pressure. Only one read is outstanding at a time. A finished walk raises `done` and presents the real address, the page size, the leaf entry and that entry's address, or a fault cause. These outputs stay unchanged until the next request is accepted.

Entry layout: bit 63 valid, bit 62 leaf. In a directory entry, bits [4:0] give the next index width and bits [55:8] give the next table base. In a leaf, bits [55:12] hold the page number. Fault cause bit 0 means an entry was missing. Bit 1 means a bad configuration.

Top module: `radix_walker`

## Requirements
- R1: `req_ready` is high exactly when no walk is running. A request is taken when `req_valid` and `req_ready` are both high. From then until the walk ends, `busy` is high and `done` is low.
- R2: Before every read, if the current index width is below 5 or above the remaining size, the walk ends with `fault_cause` = 2'b10 and no read is issued for that level.
- R3: The entry address is the table base with bits [2:0] cleared, plus 8 times the index. The index is `(va >> (remaining - width))` masked to `width` bits. `leaf_addr` reports the address of the leaf entry.
- R4: `rd_valid` stays high with a stable `rd_addr` until `rd_ready` is seen. There is never more than one read outstanding, and the walker issues exactly one read per level it visits.
- R5: A fetched entry with bit 63 clear ends the walk with `fault_cause` = 2'b01.
- R6: A valid entry with bit 62 clear makes the walk go down one level. The next width is taken from bits [4:0], the next base from bits [55:8] with all other bits zero, and the remaining size is reduced by the width just used.
- R7: A valid entry with bit 62 set ends the walk with no fault. `page_size` is the remaining size minus the last width. `real_addr` takes entry bits [55:12] above `page_size` bits and the request address below them, with bits [63:56] zero. `leaf_entry` is the fetched entry.
- R8: At most 4 reads are made per walk. If a fifth level would be needed, the walk ends with `fault_cause` = 2'b10 after the fourth read.
- R9: `done` and all result outputs hold their values until the next request is accepted. `fault_cause` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 64 | Address to translate |
| req_root_base | input | 64 | Byte address of the root table |
| req_root_width | input | 5 | Index width of the root table |
| req_total_size | input | 7 | Translated address bits (0 to 64) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 64 | Byte address of the entry |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, results valid |
| fault_cause | output | 2 | bit0 missing entry, bit1 bad configuration |
| real_addr | output | 64 | Translated address |
| page_size | output | 7 | Page size as a bit count |
| leaf_entry | output | 64 | Leaf entry found |
| leaf_addr | output | 64 | Byte address of the leaf entry |

## Verification
The main sweep walks every root index against every second-level index and four third-level indices of a three-level tree. Its tables mix missing entries, leaves at each depth, and a directory whose next width is too small. This separates a missing-entry fault from a bad-configuration fault at each depth, and separates leaf merges with 15, 10 and 5 preserved bits. Read-ready stalls and a response delay of one or two cycles vary with the cycle count, so stable addresses under back-pressure are checked along the way. Separate cases cover a root width of zero, a root width larger than the total size, a width equal to the remaining size (page size zero), an unaligned root base, and a table that points to itself, which must end after four reads.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
  localparam int DATA_W    = 64;
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT  = 62;
  localparam int F_NOENT   = 0;
  localparam int F_BADCFG  = 1;
  localparam logic [DATA_W-1:0] BASE_MASK  = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [DATA_W-1:0] RPN_MASK   = 64'h00FF_FFFF_FFFF_F000;
  localparam logic [DATA_W-1:0] ALIGN_MASK = 64'hFFFF_FFFF_FFFF_FFF8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } walk_state_t;
endpackage

// File: rtl/rw_entry_addr.sv
module rw_entry_addr
  import rwalk_pkg::*;
#(
  parameter int WW  = 5,
  parameter int SZW = 7
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] va,
  input  logic [WW-1:0]     width,
  input  logic [SZW-1:0]    remain,
  output logic [DATA_W-1:0] addr
);
  logic [SZW-1:0]    shift;
  logic [DATA_W-1:0] idx;

  always_comb begin
    shift = remain - SZW'(width);
    idx   = (va >> shift) & ((DATA_W'(1) << width) - DATA_W'(1));
    addr  = (base & ALIGN_MASK) + (idx << 3);
  end
endmodule

// File: rtl/rw_leaf_merge.sv
module rw_leaf_merge
  import rwalk_pkg::*;
#(
  parameter int SZW = 7
) (
  input  logic [DATA_W-1:0] entry,
  input  logic [DATA_W-1:0] va,
  input  logic [SZW-1:0]    psize,
  output logic [DATA_W-1:0] raddr
);
  logic [DATA_W-1:0] low;

  always_comb begin
    low   = (DATA_W'(1) << psize) - DATA_W'(1);
    raddr = (entry & RPN_MASK & ~low) | (va & low);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rwalk_pkg::*;
#(
  parameter int MAX_LEVELS = 4,
  parameter int MIN_WIDTH  = 5,
  parameter int WW         = 5,
  parameter int SZW        = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_va,
  input  logic [63:0]       req_root_base,
  input  logic [WW-1:0]     req_root_width,
  input  logic [SZW-1:0]    req_total_size,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [63:0]       rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        fault_cause,
  output logic [63:0]       real_addr,
  output logic [SZW-1:0]    page_size,
  output logic [63:0]       leaf_entry,
  output logic [63:0]       leaf_addr
);
  localparam int LVLW = $clog2(MAX_LEVELS + 1);

  walk_state_t       state_q;
  logic [63:0]       va_q, base_q, addr_q, ent_addr, merged;
  logic [WW-1:0]     w_q;
  logic [SZW-1:0]    rem_q, rem_next;
  logic [LVLW-1:0]   lvl_q;
  logic              cfg_bad, accept;

  rw_entry_addr #(.WW(WW), .SZW(SZW)) u_addr (
    .base(base_q), .va(va_q), .width(w_q), .remain(rem_q), .addr(ent_addr)
  );

  rw_leaf_merge #(.SZW(SZW)) u_merge (
    .entry(rd_rsp_data), .va(va_q), .psize(rem_next), .raddr(merged)
  );

  always_comb begin
    cfg_bad   = (lvl_q == LVLW'(MAX_LEVELS)) || (w_q < WW'(MIN_WIDTH)) ||
                (SZW'(w_q) > rem_q);
    rem_next  = rem_q - SZW'(w_q);
    busy      = (state_q != ST_IDLE);
    req_ready = !busy;
    accept    = req_valid && req_ready;
    rd_valid  = (state_q == ST_ISSUE) && !cfg_bad;
    rd_addr   = ent_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      addr_q      <= '0;
      w_q         <= '0;
      rem_q       <= '0;
      lvl_q       <= '0;
      done        <= 1'b0;
      fault_cause <= '0;
      real_addr   <= '0;
      page_size   <= '0;
      leaf_entry  <= '0;
      leaf_addr   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          va_q        <= req_va;
          base_q      <= req_root_base;
          w_q         <= req_root_width;
          rem_q       <= req_total_size;
          lvl_q       <= '0;
          done        <= 1'b0;
          fault_cause <= '0;
          state_q     <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (cfg_bad) begin
            fault_cause[F_BADCFG] <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (rd_ready) begin
            addr_q  <= ent_addr;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (rd_rsp_valid) begin
          lvl_q <= lvl_q + LVLW'(1);
          if (!rd_rsp_data[VALID_BIT]) begin
            fault_cause[F_NOENT] <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (rd_rsp_data[LEAF_BIT]) begin
            rem_q      <= rem_next;
            page_size  <= rem_next;
            real_addr  <= merged;
            leaf_entry <= rd_rsp_data;
            leaf_addr  <= addr_q;
            done       <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            rem_q   <= rem_next;
            w_q     <= rd_rsp_data[WW-1:0];
            base_q  <= rd_rsp_data & BASE_MASK;
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: a stalled read keeps its request and address
  a_r4_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R1: no read while the request side is open
  a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_valid);

  // R1: busy and done never overlap
  a_r1_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R9: results hold until a new request
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req_valid |=> done && $stable(fault_cause) && $stable(real_addr)
      && $stable(page_size) && $stable(leaf_addr));

  // R9: at most one cause
  a_r9_one_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_cause));
endmodule

// File: tb/sim_radix_walker.sv
module sim_radix_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0, req_root_base = '0;
  logic [4:0]  req_root_width = '0;
  logic [6:0]  req_total_size = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [63:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic        busy, done;
  logic [1:0]  fault_cause;
  logic [63:0] real_addr, leaf_entry, leaf_addr;
  logic [6:0]  page_size;

  int errors = 0, checks = 0, rdcnt = 0, cyc = 0;
  logic [63:0] mem [128];

  radix_walker u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [63:0] mrd(input logic [63:0] a);
    if (a < 64'h400) return mem[a[9:3]];
    return 64'h0;
  endfunction

  function automatic logic [63:0] rpn(input int x);
    return 64'h00A5_5A00_0000_7000 | (64'(x) << 24);
  endfunction

  // memory responder: stalls on ready, 1 or 2 cycle latency
  initial begin
    logic pend = 1'b0;
    int lat = 0;
    logic [63:0] pa = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rd_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mrd(pa);
          pend = 1'b0;
        end else lat--;
      end
      rd_ready = (cyc % 3) != 1;
      if (rd_valid && rd_ready && !pend) begin
        pend = 1'b1; pa = rd_addr; lat = cyc % 2; rdcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic [63:0] base,
                      input logic [4:0] w0, input logic [6:0] tot);
    logic [1:0]  ef = 2'b00;
    logic [63:0] er = '0, ee = '0, ea = '0, b = base;
    logic [6:0]  rem = tot, ep = '0;
    logic [4:0]  w = w0;
    int er_cnt = 0, tmo = 0;
    logic [63:0] hr, hl;
    logic [1:0]  hf;
    // expected result from the requirements
    for (int lv = 0; lv < 8; lv++) begin
      logic [63:0] a, e, low;
      if (lv == 4 || w < 5 || 7'(w) > rem) begin ef = 2'b10; break; end
      a = (b & ~64'h7) + (((va >> (rem - 7'(w))) & ((64'd1 << w) - 1)) << 3);
      e = mrd(a); er_cnt++;
      if (!e[63]) begin ef = 2'b01; break; end
      rem = rem - 7'(w);
      if (e[62]) begin
        low = (64'd1 << rem) - 1;
        er = (e & 64'h00FF_FFFF_FFFF_F000 & ~low) | (va & low);
        ep = rem; ee = e; ea = a; break;
      end
      w = e[4:0]; b = e & 64'h00FF_FFFF_FFFF_FF00;
    end
    @(negedge clk);
    chk(req_ready && !busy, "R1 ready when idle", {63'd0, req_ready}, 64'd1);
    req_va = va; req_root_base = base; req_root_width = w0;
    req_total_size = tot; req_valid = 1'b1; rdcnt = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !done, "R1 busy after accept", {62'd0, busy, done}, 64'd2);
    while (!done && tmo < 300) begin @(negedge clk); tmo++; end
    chk(done, "R1 walk finishes (watchdog)", {63'd0, done}, 64'd1);
    chk(fault_cause == ef, ef[1] ? "R2/R8 bad config" : "R5 fault cause",
        64'(fault_cause), 64'(ef));
    chk(rdcnt == er_cnt, "R4/R8 read count", 64'(rdcnt), 64'(er_cnt));
    if (ef == 2'b00) begin
      chk(real_addr == er, "R7 real address", real_addr, er);
      chk(page_size == ep, "R6/R7 page size", 64'(page_size), 64'(ep));
      chk(leaf_entry == ee, "R7 leaf entry", leaf_entry, ee);
      chk(leaf_addr == ea, "R3 leaf entry address", leaf_addr, ea);
    end
    hr = real_addr; hl = leaf_addr; hf = fault_cause;
    repeat (2) @(negedge clk);
    chk(done && real_addr == hr && leaf_addr == hl && fault_cause == hf,
        "R9 results held", real_addr, hr);
  endtask

  initial begin
    // tree: root 0x000 (w5), level two 0x100, level three 0x200, loop 0x300
    for (int i = 0; i < 32; i++) begin
      case (i % 4)
        0: mem[i] = 64'h0;
        1: mem[i] = 64'hC000_0000_0000_0000 | rpn(i);
        2: mem[i] = 64'h8000_0000_0000_0100 | 64'd5;
        default: mem[i] = 64'h8000_0000_0000_0100 | 64'd4;
      endcase
      case (i % 3)
        0: mem[32 + i] = 64'h0;
        1: mem[32 + i] = 64'hC000_0000_0000_0000 | rpn(100 + i);
        default: mem[32 + i] = 64'h8000_0000_0000_0200 | 64'd5;
      endcase
      mem[64 + i] = (i % 2 == 1) ? 64'h0 : (64'hC000_0000_0000_0000 | rpn(200 + i));
      mem[96 + i] = 64'h8000_0000_0000_0300 | 64'd5;
    end
    repeat (3) @(negedge clk);
    chk(!done && !busy && req_ready && !rd_valid && fault_cause == 2'b00,
        "R1 reset state", {60'd0, done, busy, req_ready, rd_valid}, 64'd2);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        for (int k = 0; k < 4; k++)
          walk(64'hF0F0_0000_0000_0000 | (64'(i) << 15) | (64'(j) << 10) |
               (64'(k) << 5) | 64'((i + j + k) % 32), 64'h0, 5'd5, 7'd20);
    walk(64'h0000_0000_0002_8000, 64'h0, 5'd0, 7'd20);   // R2 width zero
    walk(64'h0000_0000_0002_8000, 64'h0, 5'd4, 7'd20);   // R2 width four
    walk(64'h1, 64'h0, 5'd5, 7'd4);                       // R2 width above size
    walk(64'h0000_0000_0000_0021, 64'h0, 5'd5, 7'd5);     // R7 page size zero
    walk(64'h0000_0000_0000_8000, 64'h5, 5'd5, 7'd20);    // R3 unaligned base
    walk(64'h0123_4567_89AB_CDEF, 64'h300, 5'd5, 7'd40);  // R8 level limit
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule